// File: doc/BRIEF.md
# Serial Peripheral FIFO Status and Interrupt Controller

This block sits between a bus-side register decoder and a serial shift engine. It holds a transmit FIFO, which the bus fills and the serial engine drains, and a receive FIFO, which the serial engine fills and the bus drains. It reports the entry count of each FIFO. It compares each count with a programmable threshold, and the two comparisons run in opposite directions. Misuse from either side of either FIFO is caught as overrun or underrun.

Events are latched into an eight-bit sticky interrupt flag set and a four-bit wake flag set. Writing a 1 to a flag bit clears it. Per-bit enable masks reduce each set to a single interrupt or wake output. The two threshold conditions also drive one DMA request per direction, and each request is gated by its own enable. A flush input per FIFO empties that FIFO and discards all status that belongs to it.

Top module: `spi_fifo_status`

## Requirements
- R1: Each FIFO returns words in the order they were accepted. `tx_level` and `rx_level` give the entry count, from 0 up to DEPTH (32 by default, a 6-bit count). Both counts are 0 during and after reset.
- R2: The transmit threshold condition is true while `tx_level` is strictly less than `tx_thresh`. `dma_tx_req` equals this condition ANDed with `dma_tx_en`, so clearing the enable drops a pending request in the same cycle.
- R3: The receive threshold condition is true while `rx_level` is strictly greater than `rx_thresh`. `dma_rx_req` equals this condition ANDed with `dma_rx_en`, and clearing the enable drops the request in the same cycle.
- R4: The interrupt flag bits are: 0 transmit threshold, 1 transmit empty, 2 receive threshold, 3 receive full, 4 transmit overrun, 5 transmit underrun, 6 receive overrun, 7 receive underrun. Bits 0 to 3 set on the clock edge after their condition goes from false to true. A condition that is already true when reset is released sets nothing.
- R5: A bus write (`bus_wr`) while the transmit FIFO is full is dropped and sets bit 4. A serial pop (`ser_pop`) while it is empty changes nothing and sets bit 5.
- R6: A serial push (`ser_push`) while the receive FIFO is full is dropped and sets bit 6. A bus read (`bus_rd`) while it is empty changes nothing and sets bit 7.
- R7: On a `flag_wr` cycle, each 1 in `flag_wdata` clears that flag at the next edge and each 0 leaves its flag unchanged. If a flag is set and cleared in the same cycle, it ends up set.
- R8: `tx_flush` or `rx_flush` empties that FIFO at the next edge and clears that FIFO's interrupt flags (transmit: 0, 1, 4, 5; receive: 2, 3, 6, 7) and wake flags (transmit: 0, 1; receive: 2, 3). A flush overrides a push, a pop or a flag set in the same cycle, and the conditions it leaves true do not set flags afterwards.
- R9: `irq` is the OR over all bits of `int_flags & int_en`, with no register delay.
- R10: The wake flags use bits 0 to 3 with the same meaning as interrupt bits 0 to 3 and set on the same edges. They are cleared with `wake_wr`/`wake_wdata` using the write-1 rule of R7. `wake` is the OR of `wake_flags & wake_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe into the transmit FIFO |
| bus_wdata | input | DW | Word written into the transmit FIFO |
| bus_rd | input | 1 | Bus read strobe, pops the receive FIFO |
| bus_rdata | output | DW | Head of the receive FIFO |
| ser_pop | input | 1 | Serial engine pop of the transmit FIFO |
| ser_txdata | output | DW | Head of the transmit FIFO |
| ser_push | input | 1 | Serial engine push into the receive FIFO |
| ser_rxdata | input | DW | Word pushed into the receive FIFO |
| tx_flush | input | 1 | Empty the transmit FIFO and clear its status |
| rx_flush | input | 1 | Empty the receive FIFO and clear its status |
| tx_thresh | input | THR_W | Transmit threshold |
| rx_thresh | input | THR_W | Receive threshold |
| dma_tx_en | input | 1 | Transmit DMA request enable |
| dma_rx_en | input | 1 | Receive DMA request enable |
| int_en | input | 8 | Interrupt enable mask |
| wake_en | input | 4 | Wake enable mask |
| flag_wr | input | 1 | Interrupt flag write strobe |
| flag_wdata | input | 8 | Write-1-to-clear data for interrupt flags |
| wake_wr | input | 1 | Wake flag write strobe |
| wake_wdata | input | 4 | Write-1-to-clear data for wake flags |
| tx_level | output | LVL_W | Transmit FIFO entry count |
| rx_level | output | LVL_W | Receive FIFO entry count |
| int_flags | output | 8 | Sticky interrupt flags |
| wake_flags | output | 4 | Sticky wake flags |
| irq | output | 1 | Masked interrupt output |
| wake | output | 1 | Masked wake output |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The bench steps each FIFO across its threshold by exactly one entry. A comparison that used "less or equal" or "greater or equal" would therefore move the DMA request one word early. It fills both FIFOs to 32 and then writes once more. The scoreboard then detects a design that lets the extra word through or wraps its pointers. It lines up a set and a write-1 clear of the same flag in one cycle, which a design that gives the clear priority loses. It also flushes while pushing, which catches both a push that survives the flush and an empty flag that fires again after it.

// File: rtl/spi_fifo_stat_pkg.sv
package spi_fifo_stat_pkg;
   localparam int NUM_FLAGS = 8;
   localparam int NUM_WAKE  = 4;

   localparam int FL_TX_THR   = 0;
   localparam int FL_TX_EMPTY = 1;
   localparam int FL_RX_THR   = 2;
   localparam int FL_RX_FULL  = 3;
   localparam int FL_TX_OVR   = 4;
   localparam int FL_TX_UND   = 5;
   localparam int FL_RX_OVR   = 6;
   localparam int FL_RX_UND   = 7;

   localparam logic [NUM_FLAGS-1:0] TX_FLAG_MASK = 8'b0011_0011;
   localparam logic [NUM_FLAGS-1:0] RX_FLAG_MASK = 8'b1100_1100;
   localparam logic [NUM_WAKE-1:0]  TX_WAKE_MASK = 4'b0011;
   localparam logic [NUM_WAKE-1:0]  RX_WAKE_MASK = 4'b1100;
endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
   parameter int DEPTH = 32,
   parameter int DW    = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [AW:0]   level,
   output logic          full,
   output logic          empty,
   output logic          ovr_evt,
   output logic          und_evt
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("sfs_fifo: DEPTH must be a power of two of at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("sfs_fifo: DW must be positive");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW:0]   wr_ptr, rd_ptr;
   logic          push_ok, pop_ok;

   assign level   = wr_ptr - rd_ptr;
   assign full    = (level == (AW+1)'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push & ~full & ~flush;
   assign pop_ok  = pop & ~empty & ~flush;
   assign ovr_evt = push & full & ~flush;
   assign und_evt = pop & empty & ~flush;
   assign rdata   = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr[AW-1:0]] <= wdata;
   end

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= (AW+1)'(DEPTH)); // R1
   AST_OVR_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> full); // R5
   AST_UND_STAYS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push && !flush) |=> empty); // R6
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty); // R8
endmodule

// File: rtl/sfs_edge.sv
module sfs_edge #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] cond,
   input  logic [N-1:0] reload,
   output logic [N-1:0] rise
);
   if (N < 1) begin : g_bad_n
      $error("sfs_edge: N must be positive");
   end

   logic [N-1:0] prev;

   // prev starts as all ones: a condition already true at reset is not an edge
   always_ff @(posedge clk) begin
      if (!rst_n) prev <= '1;
      else        prev <= cond | reload;
   end

   assign rise = cond & ~prev;

   for (genvar g = 0; g < N; g++) begin : g_ast
      AST_NO_RISE_AFTER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
         reload[g] |=> !rise[g]); // R8
   end
endmodule

// File: rtl/sfs_w1c_flags.sv
module sfs_w1c_flags #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] kill,
   input  logic         clr_we,
   input  logic [N-1:0] clr_data,
   output logic [N-1:0] q
);
   if (N < 1) begin : g_bad_n
      $error("sfs_w1c_flags: N must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (kill[i])                     q[i] <= 1'b0;
            else if (set[i])                 q[i] <= 1'b1;
            else if (clr_we && clr_data[i])  q[i] <= 1'b0;
         end
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_ast
      AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (set[g] && !kill[g]) |=> q[g]); // R7
      AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
         (q[g] && !kill[g] && !(clr_we && clr_data[g])) |=> q[g]); // R7
      AST_ONE_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we && clr_data[g] && !set[g]) |=> !q[g]); // R7
      AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         kill[g] |=> !q[g]); // R8
   end
endmodule

// File: rtl/spi_fifo_status.sv
module spi_fifo_status
   import spi_fifo_stat_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int DW     = 16,
   parameter int THR_W  = 5,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [DW-1:0]        bus_wdata,
   input  logic                 bus_rd,
   output logic [DW-1:0]        bus_rdata,
   input  logic                 ser_pop,
   output logic [DW-1:0]        ser_txdata,
   input  logic                 ser_push,
   input  logic [DW-1:0]        ser_rxdata,
   input  logic                 tx_flush,
   input  logic                 rx_flush,
   input  logic [THR_W-1:0]     tx_thresh,
   input  logic [THR_W-1:0]     rx_thresh,
   input  logic                 dma_tx_en,
   input  logic                 dma_rx_en,
   input  logic [NUM_FLAGS-1:0] int_en,
   input  logic [NUM_WAKE-1:0]  wake_en,
   input  logic                 flag_wr,
   input  logic [NUM_FLAGS-1:0] flag_wdata,
   input  logic                 wake_wr,
   input  logic [NUM_WAKE-1:0]  wake_wdata,
   output logic [LVL_W-1:0]     tx_level,
   output logic [LVL_W-1:0]     rx_level,
   output logic [NUM_FLAGS-1:0] int_flags,
   output logic [NUM_WAKE-1:0]  wake_flags,
   output logic                 irq,
   output logic                 wake,
   output logic                 dma_tx_req,
   output logic                 dma_rx_req
);
   localparam int CW = (LVL_W > THR_W) ? LVL_W : THR_W;

   if (THR_W < 1 || THR_W > LVL_W) begin : g_bad_thr
      $error("spi_fifo_status: THR_W must lie in 1..LVL_W");
   end

   logic tx_full, tx_empty, tx_ovr, tx_und;
   logic rx_full, rx_empty, rx_ovr, rx_und;

   sfs_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txf (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush),
      .push(bus_wr), .wdata(bus_wdata), .pop(ser_pop), .rdata(ser_txdata),
      .level(tx_level), .full(tx_full), .empty(tx_empty),
      .ovr_evt(tx_ovr), .und_evt(tx_und));

   sfs_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxf (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush),
      .push(ser_push), .wdata(ser_rxdata), .pop(bus_rd), .rdata(bus_rdata),
      .level(rx_level), .full(rx_full), .empty(rx_empty),
      .ovr_evt(rx_ovr), .und_evt(rx_und));

   // threshold comparisons in a common width; TX is "below", RX is "above"
   logic [CW-1:0] tx_lvl_c, rx_lvl_c, tx_thr_c, rx_thr_c;
   logic          tx_below, rx_above;

   assign tx_lvl_c = CW'(tx_level);
   assign rx_lvl_c = CW'(rx_level);
   assign tx_thr_c = CW'(tx_thresh);
   assign rx_thr_c = CW'(rx_thresh);
   assign tx_below = (tx_lvl_c < tx_thr_c);
   assign rx_above = (rx_lvl_c > rx_thr_c);

   logic [NUM_WAKE-1:0]  lvl_cond, lvl_reload, lvl_rise;
   logic [NUM_FLAGS-1:0] int_set, int_kill;
   logic [NUM_WAKE-1:0]  wake_kill;

   always_comb begin
      lvl_cond             = '0;
      lvl_cond[FL_TX_THR]   = tx_below;
      lvl_cond[FL_TX_EMPTY] = tx_empty;
      lvl_cond[FL_RX_THR]   = rx_above;
      lvl_cond[FL_RX_FULL]  = rx_full;

      lvl_reload = ({NUM_WAKE{tx_flush}} & TX_WAKE_MASK)
                 | ({NUM_WAKE{rx_flush}} & RX_WAKE_MASK);

      int_set                = '0;
      int_set[NUM_WAKE-1:0]  = lvl_rise;
      int_set[FL_TX_OVR]     = tx_ovr;
      int_set[FL_TX_UND]     = tx_und;
      int_set[FL_RX_OVR]     = rx_ovr;
      int_set[FL_RX_UND]     = rx_und;

      int_kill  = ({NUM_FLAGS{tx_flush}} & TX_FLAG_MASK)
                | ({NUM_FLAGS{rx_flush}} & RX_FLAG_MASK);
      wake_kill = lvl_reload;
   end

   sfs_edge #(.N(NUM_WAKE)) u_edge (
      .clk(clk), .rst_n(rst_n), .cond(lvl_cond), .reload(lvl_reload),
      .rise(lvl_rise));

   sfs_w1c_flags #(.N(NUM_FLAGS)) u_int_flags (
      .clk(clk), .rst_n(rst_n), .set(int_set), .kill(int_kill),
      .clr_we(flag_wr), .clr_data(flag_wdata), .q(int_flags));

   sfs_w1c_flags #(.N(NUM_WAKE)) u_wake_flags (
      .clk(clk), .rst_n(rst_n), .set(lvl_rise), .kill(wake_kill),
      .clr_we(wake_wr), .clr_data(wake_wdata), .q(wake_flags));

   assign irq        = |(int_flags & int_en);
   assign wake       = |(wake_flags & wake_en);
   assign dma_tx_req = dma_tx_en & tx_below;
   assign dma_rx_req = dma_rx_en & rx_above;

   AST_TX_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flush |=> (((int_flags & TX_FLAG_MASK) == '0) && tx_level == '0)); // R8
   AST_RX_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush |=> (((int_flags & RX_FLAG_MASK) == '0) && rx_level == '0)); // R8
   AST_TX_UND_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_pop && tx_level == '0 && !tx_flush) |=> int_flags[FL_TX_UND]); // R5
   AST_RX_OVR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_push && rx_full && !rx_flush) |=> int_flags[FL_RX_OVR]); // R6
endmodule

// File: tb/spi_fifo_status_test.sv
module spi_fifo_status_test;
   localparam int DEPTH = 32;
   localparam int DW    = 16;

   logic clk = 1'b0;
   logic rst_n;
   logic bus_wr, bus_rd, ser_pop, ser_push, tx_flush, rx_flush;
   logic [DW-1:0] bus_wdata, ser_rxdata, bus_rdata, ser_txdata;
   logic [4:0] tx_thresh, rx_thresh;
   logic dma_tx_en, dma_rx_en, flag_wr, wake_wr;
   logic [7:0] int_en, flag_wdata, int_flags;
   logic [3:0] wake_en, wake_wdata, wake_flags;
   logic [5:0] tx_level, rx_level;
   logic irq, wake, dma_tx_req, dma_rx_req;

   spi_fifo_status uut (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .ser_pop(ser_pop), .ser_txdata(ser_txdata), .ser_push(ser_push), .ser_rxdata(ser_rxdata),
      .tx_flush(tx_flush), .rx_flush(rx_flush),
      .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
      .dma_tx_en(dma_tx_en), .dma_rx_en(dma_rx_en),
      .int_en(int_en), .wake_en(wake_en),
      .flag_wr(flag_wr), .flag_wdata(flag_wdata),
      .wake_wr(wake_wr), .wake_wdata(wake_wdata),
      .tx_level(tx_level), .rx_level(rx_level),
      .int_flags(int_flags), .wake_flags(wake_flags),
      .irq(irq), .wake(wake), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req));

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;
   logic [DW-1:0] txq[$];
   logic [DW-1:0] rxq[$];
   event tx_mon_ev, rx_mon_ev;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // driver tasks: the transmit and receive scoreboards are filled here
   task automatic bus_write(input logic [DW-1:0] d);
      bus_wr = 1'b1; bus_wdata = d;
      if (txq.size() < DEPTH) txq.push_back(d);
      step();
      bus_wr = 1'b0;
   endtask

   task automatic serial_pop();
      ser_pop = 1'b1;
      -> tx_mon_ev;
      step();
      ser_pop = 1'b0;
   endtask

   task automatic serial_push(input logic [DW-1:0] d);
      ser_push = 1'b1; ser_rxdata = d;
      if (rxq.size() < DEPTH) rxq.push_back(d);
      step();
      ser_push = 1'b0;
   endtask

   task automatic bus_read();
      bus_rd = 1'b1;
      -> rx_mon_ev;
      step();
      bus_rd = 1'b0;
   endtask

   // monitors: compare the FIFO heads with the scoreboards
   always @(tx_mon_ev) begin
      #1;
      if (txq.size() > 0) check("R1", "tx word order", 32'(ser_txdata), 32'(txq.pop_front()));
   end

   always @(rx_mon_ev) begin
      #1;
      if (rxq.size() > 0) check("R1", "rx word order", 32'(bus_rdata), 32'(rxq.pop_front()));
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      bus_wr = 0; bus_rd = 0; ser_pop = 0; ser_push = 0; tx_flush = 0; rx_flush = 0;
      bus_wdata = '0; ser_rxdata = '0;
      tx_thresh = 5'd4; rx_thresh = 5'd2;
      dma_tx_en = 0; dma_rx_en = 0; int_en = '0; wake_en = '0;
      flag_wr = 0; flag_wdata = '0; wake_wr = 0; wake_wdata = '0;
      repeat (3) step();
      check("R1", "tx level in reset", 32'(tx_level), 0);
      check("R1", "rx level in reset", 32'(rx_level), 0);
      check("R4", "flags in reset", 32'(int_flags), 0);
      check("R9", "irq in reset", 32'(irq), 0);
      rst_n = 1'b1;
      step(); step();
      check("R4", "no flag from reset-true condition", 32'(int_flags), 0);
      check("R10", "no wake flag after reset", 32'(wake_flags), 0);

      // R2: transmit threshold, strictly below
      dma_tx_en = 1'b1; #1;
      check("R2", "tx dma req at level 0", 32'(dma_tx_req), 1);
      step();
      bus_write(16'h0A01); bus_write(16'h0A02); bus_write(16'h0A03);
      check("R2", "tx level 3", 32'(tx_level), 3);
      check("R2", "tx req at level 3", 32'(dma_tx_req), 1);
      bus_write(16'h0A04);
      check("R2", "tx req off at level equal threshold", 32'(dma_tx_req), 0);
      bus_write(16'h0A05);
      check("R1", "tx level 5", 32'(tx_level), 5);
      for (int i = 0; i < 5; i++) serial_pop();
      step();
      check("R1", "tx level drained", 32'(tx_level), 0);
      check("R4", "threshold and empty bits", 32'(int_flags), 32'h03);
      check("R10", "wake flags mirror", 32'(wake_flags), 32'h3);
      check("R9", "irq masked", 32'(irq), 0);

      // R9 / R10 masking
      int_en = 8'h02; #1;
      check("R9", "irq with empty enabled", 32'(irq), 1);
      int_en = 8'h10; #1;
      check("R9", "irq with unset bit enabled", 32'(irq), 0);
      check("R10", "wake masked", 32'(wake), 0);
      wake_en = 4'h1; #1;
      check("R10", "wake enabled", 32'(wake), 1);
      step();

      // R7 write-1-to-clear
      flag_wr = 1; flag_wdata = 8'h01; step(); flag_wr = 0;
      check("R7", "clear bit 0", 32'(int_flags), 32'h02);
      flag_wr = 1; flag_wdata = 8'h00; step(); flag_wr = 0;
      check("R7", "zero write keeps", 32'(int_flags), 32'h02);
      wake_wr = 1; wake_wdata = 4'h2; step(); wake_wr = 0;
      check("R10", "wake clear bit 1", 32'(wake_flags), 32'h1);

      // R5 underrun, then set-beats-clear
      serial_pop();
      check("R5", "tx underrun flag", 32'(int_flags), 32'h22);
      check("R5", "tx level stays 0", 32'(tx_level), 0);
      ser_pop = 1; flag_wr = 1; flag_wdata = 8'h20; step();
      ser_pop = 0; flag_wr = 0;
      check("R7", "set wins over clear", 32'(int_flags), 32'h22);
      flag_wr = 1; flag_wdata = 8'h20; step(); flag_wr = 0;
      check("R7", "plain clear", 32'(int_flags), 32'h02);

      // R5 overrun at full, dropped word checked by scoreboard
      for (int i = 0; i < DEPTH; i++) bus_write(DW'(16'h0100 + i * 3));
      check("R1", "tx level full", 32'(tx_level), DEPTH);
      bus_write(16'hDEAD);
      check("R5", "tx overrun flag", 32'(int_flags), 32'h12);
      check("R5", "tx level stays full", 32'(tx_level), DEPTH);
      for (int i = 0; i < DEPTH; i++) serial_pop();
      step();
      check("R4", "flags after drain", 32'(int_flags), 32'h13);
      check("R10", "wake after drain", 32'(wake_flags), 32'h3);

      // R8 flush beats a push in the same cycle
      bus_write(16'h0B01); bus_write(16'h0B02);
      tx_flush = 1; bus_wr = 1; bus_wdata = 16'h0B03; step();
      tx_flush = 0; bus_wr = 0; txq.delete();
      check("R8", "tx level after flush", 32'(tx_level), 0);
      check("R8", "tx flags cleared", 32'(int_flags), 32'h00);
      check("R8", "tx wake flags cleared", 32'(wake_flags), 32'h0);
      step();
      check("R8", "no retrigger after flush", 32'(int_flags), 32'h00);
      check("R2", "tx req after flush", 32'(dma_tx_req), 1);
      dma_tx_en = 0; #1;
      check("R2", "tx req dropped by enable", 32'(dma_tx_req), 0);
      step();

      // R3 receive threshold, strictly above
      dma_rx_en = 1;
      serial_push(16'h0C01); serial_push(16'h0C02);
      check("R3", "rx req off at level equal threshold", 32'(dma_rx_req), 0);
      serial_push(16'h0C03);
      check("R3", "rx req on above threshold", 32'(dma_rx_req), 1);
      step();
      check("R4", "rx threshold bit", 32'(int_flags), 32'h04);
      for (int i = 0; i < 3; i++) bus_read();
      check("R1", "rx level drained", 32'(rx_level), 0);
      bus_read();
      check("R6", "rx underrun flag", 32'(int_flags), 32'h84);

      // R6 overrun at full
      for (int i = 0; i < DEPTH; i++) serial_push(DW'(16'h2000 + i));
      serial_push(16'hBEEF);
      step();
      check("R6", "rx full and overrun flags", 32'(int_flags), 32'hCC);
      check("R6", "rx level stays full", 32'(rx_level), DEPTH);
      check("R10", "rx wake flags", 32'(wake_flags), 32'hC);
      for (int i = 0; i < 4; i++) bus_read();
      dma_rx_en = 0; #1;
      check("R3", "rx req dropped by enable", 32'(dma_rx_req), 0);
      step();
      rx_flush = 1; bus_rd = 1; step();
      rx_flush = 0; bus_rd = 0; rxq.delete();
      check("R8", "rx level after flush", 32'(rx_level), 0);
      check("R8", "rx flags cleared", 32'(int_flags), 32'h00);
      check("R8", "rx wake flags cleared", 32'(wake_flags), 32'h0);
      step();
      finish_run();
   end
endmodule